// File: doc/BRIEF.md
# Floppy Data Rate Select Register

This block is the host-writable rate select register of a floppy disk controller. A host write loads a two-bit rate field. The block combines that field with a two-bit drive-type input to produce two results. The first is the active MFM and FM data rates, reported in kbps; a value of zero means that the combination has no FM rate. The second is the levels on the two density pins that go out to the drive.

The same register also holds two control bits. A manual low-power bit gates the controller clock off until something wakes it. A self-clearing software reset bit fires a single reset pulse into the controller. A host access to the data register or the main status register ends low-power mode, and so does either kind of reset. The reset from the digital output register is passed straight through to the internal reset.

Top module: `fdc_rate_sel`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the rate field is 2'b10, low-power is off, clk_en is 1, int_rst is 0 (with dor_rst low) and rd_data reads 8'h02.
- R2: A write with data bit 6 set (and bit 7 clear) enters low-power mode: from the next cycle clk_en is 0 and rd_data bit 6 reads 1. A later write with bit 6 clear leaves low-power mode.
- R3: A cycle with data_acc or stat_acc high ends low-power mode, and clk_en is 1 from the next cycle. An access in the same cycle as a write that sets bit 6 wins over that write.
- R4: A write with bit 7 set makes int_rst high for exactly the one following cycle. That write also ends low-power mode, even if its bit 6 is set. It leaves the rate field unchanged from the value written. rd_data bit 7 always reads 0.
- R5: dor_rst drives int_rst high in the same cycle. While dor_rst is high, it also ends low-power mode.
- R6: For drive type 00, rate codes 00/01/10/11 give MFM rates of 500/300/250/1000 kbps and FM rates of 250/150/125/0 kbps.
- R7: For drive type 01, rate code 01 gives 500 kbps MFM and 250 kbps FM. The other codes are as in R6.
- R8: For drive type 10, rate code 01 gives 2000 kbps MFM and 0 FM. The other codes are as in R6.
- R9: Drive type 11 behaves exactly as type 00, for both the rates and the density pins.
- R10: The density signal is high when the MFM rate is 500, 1000 or 2000 kbps. The density pins dens_pins[1:0] are {code[0], density} for type 00, {code[0], code[1]} for type 01, and {code[0], ~density} for type 10.
- R11: Written bits 5:0 are stored and read back on rd_data[5:0], and rd_data[6] reflects low-power. Bits 5:2 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_stb | input | 1 | Decoded write strobe for this register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read-back value: bit 7 is 0, bit 6 is low-power, bits 5:0 are stored |
| data_acc | input | 1 | Strobe for an access to the data register |
| stat_acc | input | 1 | Strobe for an access to the main status register |
| dor_rst | input | 1 | Reset request from the digital output register |
| drv_type | input | 2 | Drive-type field |
| clk_en | output | 1 | Controller clock and separator enable, low in low-power mode |
| int_rst | output | 1 | Internal controller reset |
| rate_code | output | 2 | Current rate select field |
| mfm_kbps | output | 12 | Active MFM data rate in kbps |
| fm_kbps | output | 12 | Active FM data rate in kbps, 0 when none |
| dens_pins | output | 2 | Density pins to the drive |

## Verification
The bench walks every pairing of drive type and rate code. This catches a design that applies the three-mode or tape override to the wrong code, or that maps the density pins for the wrong type. It also catches one that treats the reserved type as anything other than the standard type. The bench then targets the conflicts among the low-power controls: an access in the same cycle as a write of bit 6, and one write that sets both bit 6 and bit 7. A design that ranks the write above the wake-up conditions would leave the clock gated in those cases. The bench also checks that the reset pulse lasts one cycle and that bit 7 reads back as 0. A design that failed to self-clear would hold the controller in reset. Finally, it writes ones to bits 5:2 and checks that every output is unchanged.

// File: rtl/fdc_rate_pkg.sv
// Package: shared drive-type encoding, register bit positions and rate values
// for the floppy rate select block. Assumes an 8-bit register.
package fdc_rate_pkg;

    typedef enum logic [1:0] {
        DT_STD   = 2'b00,
        DT_3MODE = 2'b01,
        DT_TAPE  = 2'b10,
        DT_RSVD  = 2'b11
    } drv_type_e;

    localparam int REG_W     = 8;
    localparam int LP_BIT    = 6;
    localparam int SR_BIT    = 7;
    localparam int STORE_W   = 6;
    localparam int CODE_W    = 2;
    localparam logic [CODE_W-1:0] CODE_RESET = 2'b10;

    localparam int KBPS_2000 = 2000;
    localparam int KBPS_1000 = 1000;
    localparam int KBPS_500  = 500;
    localparam int KBPS_300  = 300;
    localparam int KBPS_250  = 250;
    localparam int KBPS_150  = 150;
    localparam int KBPS_125  = 125;

    // Fold unlisted drive types onto the standard type.
    function automatic drv_type_e norm_type(input logic [1:0] t);
        drv_type_e r;
        case (t)
            2'b01:   r = DT_3MODE;
            2'b10:   r = DT_TAPE;
            default: r = DT_STD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fdc_rate_regfile.sv
// Module: register storage, manual low-power state and self-clearing
// software reset. Assumes wr_stb is a single-cycle decoded strobe and that
// data/status access strobes are one cycle per access.
module fdc_rate_regfile
    import fdc_rate_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              data_acc,
    input  logic              stat_acc,
    input  logic              dor_rst,
    output logic [DATA_W-1:0] rd_data,
    output logic              lp_q,
    output logic              srst_q,
    output logic [CODE_W-1:0] code_q
);

    localparam int UPPER_W = STORE_W - CODE_W;

    logic [UPPER_W-1:0] upper_q;
    logic               sr_req;
    logic               wake;
    logic               lp_nxt;

    assign sr_req = wr_stb && wr_data[SR_BIT];
    assign wake   = data_acc || stat_acc || dor_rst || sr_req;

    // Next low-power state: wake-up conditions outrank a write of bit 6.
    always_comb begin
        lp_nxt = lp_q;
        if (wr_stb) lp_nxt = wr_data[LP_BIT];
        if (wake)   lp_nxt = 1'b0;
    end

    // Stored fields: rate code and the inert upper bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= CODE_RESET;
            upper_q <= '0;
        end else if (wr_stb) begin
            code_q  <= wr_data[CODE_W-1:0];
            upper_q <= wr_data[STORE_W-1:CODE_W];
        end
    end

    // Low-power flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) lp_q <= 1'b0;
        else        lp_q <= lp_nxt;
    end

    // One-cycle software reset pulse following a bit-7 write.
    always_ff @(posedge clk) begin
        if (!rst_n) srst_q <= 1'b0;
        else        srst_q <= sr_req;
    end

    // Read-back: reset bit always reads zero.
    always_comb begin
        rd_data                   = '0;
        rd_data[CODE_W-1:0]       = code_q;
        rd_data[STORE_W-1:CODE_W] = upper_q;
        rd_data[LP_BIT]           = lp_q;
        rd_data[SR_BIT]           = 1'b0;
    end

    // R4: pulse drops after one cycle unless re-requested.
    p_srst_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_q && !sr_req) |=> !srst_q);

    // R3: any data or status access leaves low-power the next cycle.
    p_lp_exit_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc || stat_acc) |=> !lp_q);

    // R4: software reset write also leaves low-power.
    p_lp_exit_srst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sr_req |=> (!lp_q && srst_q));

endmodule

// File: rtl/fdc_rate_decode.sv
// Module: combinational rate table. Maps rate code and drive type to MFM
// and FM rates in kbps; 0 means no rate. Assumes RATE_W can hold 2000.
module fdc_rate_decode
    import fdc_rate_pkg::*;
#(
    parameter int RATE_W = 12
) (
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        dtype,
    output logic [RATE_W-1:0] mfm,
    output logic [RATE_W-1:0] fm
);

    drv_type_e t;
    assign t = norm_type(dtype);

    // Table lookup; only code 01 depends on drive type.
    always_comb begin
        case (code)
            2'b00: begin
                mfm = RATE_W'(KBPS_500);
                fm  = RATE_W'(KBPS_250);
            end
            2'b01: begin
                case (t)
                    DT_3MODE: begin
                        mfm = RATE_W'(KBPS_500);
                        fm  = RATE_W'(KBPS_250);
                    end
                    DT_TAPE: begin
                        mfm = RATE_W'(KBPS_2000);
                        fm  = '0;
                    end
                    default: begin
                        mfm = RATE_W'(KBPS_300);
                        fm  = RATE_W'(KBPS_150);
                    end
                endcase
            end
            2'b10: begin
                mfm = RATE_W'(KBPS_250);
                fm  = RATE_W'(KBPS_125);
            end
            default: begin
                mfm = RATE_W'(KBPS_1000);
                fm  = '0;
            end
        endcase
    end

endmodule

// File: rtl/fdc_dens_map.sv
// Module: density signal and pin mapping. The density signal is derived
// from code and type directly (not from the rate table) so that the two can
// be cross-checked. Assumes unlisted drive types use the standard mapping.
module fdc_dens_map
    import fdc_rate_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        dtype,
    output logic              densel,
    output logic [1:0]        pins
);

    drv_type_e t;
    assign t = norm_type(dtype);

    // Density high for the fast rates: codes 00 and 11, and 01 on non-std types.
    always_comb begin
        case (code)
            2'b00, 2'b11: densel = 1'b1;
            2'b01:        densel = (t != DT_STD);
            default:      densel = 1'b0;
        endcase
    end

    // Pin mapping per drive type.
    always_comb begin
        case (t)
            DT_3MODE: pins = {code[0], code[1]};
            DT_TAPE:  pins = {code[0], ~densel};
            default:  pins = {code[0], densel};
        endcase
    end

endmodule

// File: rtl/fdc_rate_sel.sv
// Module: top of the floppy data rate select register. Connects storage,
// rate table and density mapping; produces clock enable and internal reset.
// Assumes all strobes are synchronous to clk.
module fdc_rate_sel
    import fdc_rate_pkg::*;
#(
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              data_acc,
    input  logic              stat_acc,
    input  logic              dor_rst,
    input  logic [1:0]        drv_type,
    output logic              clk_en,
    output logic              int_rst,
    output logic [1:0]        rate_code,
    output logic [RATE_W-1:0] mfm_kbps,
    output logic [RATE_W-1:0] fm_kbps,
    output logic [1:0]        dens_pins
);

    logic lp_q;
    logic srst_q;
    logic densel;

    fdc_rate_regfile #(.DATA_W(REG_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .data_acc (data_acc),
        .stat_acc (stat_acc),
        .dor_rst  (dor_rst),
        .rd_data  (rd_data),
        .lp_q     (lp_q),
        .srst_q   (srst_q),
        .code_q   (rate_code)
    );

    fdc_rate_decode #(.RATE_W(RATE_W)) u_dec (
        .code  (rate_code),
        .dtype (drv_type),
        .mfm   (mfm_kbps),
        .fm    (fm_kbps)
    );

    fdc_dens_map u_dens (
        .code   (rate_code),
        .dtype  (drv_type),
        .densel (densel),
        .pins   (dens_pins)
    );

    // Clock gate and reset outputs.
    assign clk_en  = !lp_q;
    assign int_rst = srst_q || dor_rst;

    // R2: a plain bit-6 write with no wake-up source gates the clock next cycle.
    p_lp_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_data[LP_BIT] && !wr_data[SR_BIT] && !data_acc
         && !stat_acc && !dor_rst) |=> !clk_en);

    // R4: a bit-7 write raises the internal reset next cycle.
    p_srst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_data[SR_BIT]) |=> int_rst);

    // R10: density signal agrees with the rate table.
    p_densel_rate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        densel == (mfm_kbps == RATE_W'(KBPS_500) || mfm_kbps == RATE_W'(KBPS_1000)
                   || mfm_kbps == RATE_W'(KBPS_2000)));

    // R5: the digital output register reset reaches int_rst at once.
    p_dor_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dor_rst |-> int_rst);

endmodule

// File: tb/tb_fdc_rate_sel.sv
module tb_fdc_rate_sel;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_stb;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data;
    logic        data_acc;
    logic        stat_acc;
    logic        dor_rst;
    logic [1:0]  drv_type;
    logic        clk_en;
    logic        int_rst;
    logic [1:0]  rate_code;
    logic [11:0] mfm_kbps;
    logic [11:0] fm_kbps;
    logic [1:0]  dens_pins;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    fdc_rate_sel dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_data(rd_data), .data_acc(data_acc), .stat_acc(stat_acc),
        .dor_rst(dor_rst), .drv_type(drv_type), .clk_en(clk_en),
        .int_rst(int_rst), .rate_code(rate_code), .mfm_kbps(mfm_kbps),
        .fm_kbps(fm_kbps), .dens_pins(dens_pins)
    );

    // {type, code, mfm, fm, pins}: R6..R10 expectations
    localparam logic [29:0] VEC [16] = '{
        {2'b00, 2'b00, 12'd500,  12'd250, 2'b01},
        {2'b00, 2'b01, 12'd300,  12'd150, 2'b10},
        {2'b00, 2'b10, 12'd250,  12'd125, 2'b00},
        {2'b00, 2'b11, 12'd1000, 12'd0,   2'b11},
        {2'b01, 2'b00, 12'd500,  12'd250, 2'b00},
        {2'b01, 2'b01, 12'd500,  12'd250, 2'b10},
        {2'b01, 2'b10, 12'd250,  12'd125, 2'b01},
        {2'b01, 2'b11, 12'd1000, 12'd0,   2'b11},
        {2'b10, 2'b00, 12'd500,  12'd250, 2'b00},
        {2'b10, 2'b01, 12'd2000, 12'd0,   2'b10},
        {2'b10, 2'b10, 12'd250,  12'd125, 2'b01},
        {2'b10, 2'b11, 12'd1000, 12'd0,   2'b10},
        {2'b11, 2'b00, 12'd500,  12'd250, 2'b01},
        {2'b11, 2'b01, 12'd300,  12'd150, 2'b10},
        {2'b11, 2'b10, 12'd250,  12'd125, 2'b00},
        {2'b11, 2'b11, 12'd1000, 12'd0,   2'b11}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Write one register value; returns at the negedge after the capturing edge.
    task automatic wr(input logic [7:0] d);
        wr_stb  = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
        wr_data = '0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; wr_stb = 1'b0; wr_data = '0; data_acc = 1'b0;
        stat_acc = 1'b0; dor_rst = 1'b0; drv_type = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rate_code", rate_code, 2);
        check("R1 clk_en", clk_en, 1);
        check("R1 int_rst", int_rst, 0);
        check("R1 rd_data", rd_data, 8'h02);
        check("R1 mfm", mfm_kbps, 250);

        // R6 R7 R8 R9 R10 table walk
        for (int i = 0; i < 16; i++) begin
            drv_type = VEC[i][29:28];
            wr({6'b0, VEC[i][27:26]});
            check($sformatf("R6-8 mfm t%0d c%0d", VEC[i][29:28], VEC[i][27:26]),
                  mfm_kbps, VEC[i][25:14]);
            check($sformatf("R6-8 fm t%0d c%0d", VEC[i][29:28], VEC[i][27:26]),
                  fm_kbps, VEC[i][13:2]);
            check($sformatf("R10 pins t%0d c%0d", VEC[i][29:28], VEC[i][27:26]),
                  dens_pins, VEC[i][1:0]);
        end

        // R11 upper bits stored, inert
        drv_type = 2'b00;
        wr(8'h3D);
        check("R11 readback", rd_data, 8'h3D);
        check("R11 mfm", mfm_kbps, 300);
        check("R11 fm", fm_kbps, 150);
        check("R11 pins", dens_pins, 2'b10);
        check("R11 clk_en", clk_en, 1);
        check("R11 int_rst", int_rst, 0);

        // R2 enter / leave via write
        wr(8'h42);
        check("R2 clk_en low", clk_en, 0);
        check("R2 rd bit6", rd_data, 8'h42);
        wr(8'h02);
        check("R2 leave by write", clk_en, 1);

        // R3 data access wake
        wr(8'h42);
        data_acc = 1'b1; @(negedge clk); data_acc = 1'b0;
        check("R3 data wake", clk_en, 1);
        // R3 status access wake
        wr(8'h42);
        stat_acc = 1'b1; @(negedge clk); stat_acc = 1'b0;
        check("R3 status wake", clk_en, 1);
        // R3 access same cycle as bit-6 write
        data_acc = 1'b1;
        wr(8'h42);
        data_acc = 1'b0;
        check("R3 access beats write", clk_en, 1);

        // R4 software reset pulse
        wr(8'h41);
        check("R4 lp entered", clk_en, 0);
        wr(8'h81);
        check("R4 pulse", int_rst, 1);
        check("R4 lp cleared", clk_en, 1);
        check("R4 rd bit7", rd_data, 8'h01);
        check("R4 rate kept", rate_code, 1);
        @(negedge clk);
        check("R4 pulse ends", int_rst, 0);
        wr(8'hC2);
        check("R4 bit6 ignored", clk_en, 1);
        @(negedge clk);
        check("R4 pulse ends 2", int_rst, 0);

        // R5 dor reset
        wr(8'h42);
        dor_rst = 1'b1;
        #1;
        check("R5 immediate", int_rst, 1);
        @(negedge clk);
        dor_rst = 1'b0;
        check("R5 lp cleared", clk_en, 1);
        #1;
        check("R5 released", int_rst, 0);

        // R1 reset again mid-run
        wr(8'h7F);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        check("R1 re-reset rd", rd_data, 8'h02);
        check("R1 re-reset clk_en", clk_en, 1);

        finish_run();
    end

endmodule